// File: doc/BRIEF.md
# Post-Transmission Acknowledge Gap Detector

After a tag finishes sending its code, the reader may acknowledge it. The reader does this by shaping a short series of field gaps. This block watches the demodulated, synchronised gap level and decides whether the acknowledge arrived. It counts quarter-bit ticks from the end-of-code strobe. It samples the level at four fixed points after the code ends: 1.75, 4.75, 7.75 and 10.75 bit periods. It then compares each sample with a fixed low/high/low/high pattern.

A full match gives a one-cycle acknowledge pulse. The first mismatch gives a one-cycle fail pulse and ends the attempt. The surrounding controller uses these pulses to slow down or stop its transmissions. A control bit enables detection. While that bit is clear, the block stays idle.

Top module: `ackGapDetect`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ackPulse` and `failPulse` are low.
- R2: A `codeEnd` pulse while `ackEnable` is high starts a sequence with the tick count at zero. On the 7th `quarterTick` after it, `gapLevel` must be 0, or the attempt fails.
- R3: The later checks fall on ticks 19, 31 and 43 after `codeEnd`. They require `gapLevel` to be 1, 0 and 1 in that order.
- R4: When all four checks pass, `ackPulse` is high for exactly the one cycle after the clock edge that samples tick 43.
- R5: At the first failing check, `failPulse` is high for the one cycle after that tick's sampling edge. The block then returns to idle, and further ticks give no pulse.
- R6: `gapLevel` is ignored on every tick that is not a sample tick.
- R7: With `ackEnable` low, `codeEnd` is ignored. Lowering `ackEnable` during a sequence aborts it with no pulse.
- R8: A `codeEnd` during a sequence restarts it from tick zero. A `quarterTick` in the same cycle as `codeEnd` is not counted.
- R9: `ackPulse` and `failPulse` are never high together, and neither stays high for two cycles in a row.
- R10: Ticks that arrive without a preceding `codeEnd` give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ackEnable | input | 1 | Detection enable control bit |
| quarterTick | input | 1 | One-cycle strobe, four per bit period |
| codeEnd | input | 1 | One-cycle strobe after the last code bit |
| gapLevel | input | 1 | Synchronised demodulated gap level |
| ackPulse | output | 1 | One-cycle acknowledge result |
| failPulse | output | 1 | One-cycle failed-acknowledge result |

## Verification
The pattern is tried in its correct form and also with each of the four sample points inverted in turn. These runs show whether every check position is evaluated, and whether a failure stops the sequence at once. Between sample points the level is held at constant 0, at constant 1, and at the opposite of the next expected value. The last of these makes an early or late sample look like a mismatch, so a sample position that is off by one tick is caught. Extra runs cover a restart in mid-sequence, a restart whose start strobe coincides with a tick, enable dropped in mid-sequence, and ticks with no start strobe at all.

// File: rtl/ackGapPkg.sv
package ackGapPkg;

  typedef struct packed {
    logic clear;
    logic countTick;
    logic stepCheck;
  } dpStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } ackState_e;

endpackage

// File: rtl/ackGapDatapath.sv
module ackGapDatapath
  import ackGapPkg::*;
#(
  parameter int NUM_CHECKS = 4,
  parameter int FIRST_TICK = 7,
  parameter int SPACING = 12,
  parameter logic [NUM_CHECKS-1:0] EXPECT_LEVELS = 4'b1010
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  logic      quarterTick,
  input  logic      gapLevel,
  output logic      atSample,
  output logic      levelOk,
  output logic      lastCheck
);

  localparam int LAST_TICK = FIRST_TICK + (NUM_CHECKS - 1) * SPACING;
  localparam int CNT_W = $clog2(LAST_TICK + 1);
  localparam int IDX_W = (NUM_CHECKS > 1) ? $clog2(NUM_CHECKS) : 1;

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] nextTick;
  logic [IDX_W-1:0] checkIdx;
  logic [CNT_W-1:0] samplePos [NUM_CHECKS];

  for (genvar i = 0; i < NUM_CHECKS; i++) begin : g_pos
    assign samplePos[i] = CNT_W'(FIRST_TICK + i * SPACING);
  end

  assign nextTick  = tickCnt + 1'b1;
  assign atSample  = quarterTick && (nextTick == samplePos[checkIdx]);
  assign levelOk   = (gapLevel == EXPECT_LEVELS[checkIdx]);
  assign lastCheck = (checkIdx == IDX_W'(NUM_CHECKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      checkIdx <= '0;
    end else if (strobe.clear) begin
      tickCnt  <= '0;
      checkIdx <= '0;
    end else begin
      if (strobe.countTick) tickCnt <= nextTick;
      if (strobe.stepCheck) checkIdx <= checkIdx + 1'b1;
    end
  end

  // R3: the tick count never runs past the last sample point
  p_tick_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_W'(LAST_TICK));

  // R3: the control moves to the next check only on a matching sample tick
  p_step_on_sample_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepCheck |-> (atSample && levelOk));

endmodule

// File: rtl/ackGapControl.sv
module ackGapControl
  import ackGapPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ackEnable,
  input  logic      codeEnd,
  input  logic      quarterTick,
  input  logic      atSample,
  input  logic      levelOk,
  input  logic      lastCheck,
  output dpStrobe_t strobe,
  output logic      ackPulse,
  output logic      failPulse
);

  ackState_e state, nextState;
  logic ackNext, failNext;

  always_comb begin
    strobe    = '0;
    nextState = state;
    ackNext   = 1'b0;
    failNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ackEnable && codeEnd) begin
          strobe.clear = 1'b1;
          nextState    = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (!ackEnable) begin
          nextState = ST_IDLE;
        end else if (codeEnd) begin
          strobe.clear = 1'b1;
        end else if (quarterTick) begin
          strobe.countTick = 1'b1;
          if (atSample) begin
            if (!levelOk) begin
              failNext  = 1'b1;
              nextState = ST_IDLE;
            end else if (lastCheck) begin
              ackNext   = 1'b1;
              nextState = ST_IDLE;
            end else begin
              strobe.stepCheck = 1'b1;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackPulse  <= 1'b0;
      failPulse <= 1'b0;
    end else begin
      state     <= nextState;
      ackPulse  <= ackNext;
      failPulse <= failNext;
    end
  end

  // R9: results are exclusive and last a single cycle
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ackPulse && failPulse));
  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> !ackPulse);
  p_fail_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |=> !failPulse);

  // R7: a cleared enable forces idle and blocks an acknowledge
  p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ackEnable |=> (state == ST_IDLE));
  p_ack_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> $past(ackEnable));

  // R10: a result can only come out of an armed sequence
  p_result_armed_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse || failPulse) |-> $past(state == ST_ARMED));

endmodule

// File: rtl/ackGapDetect.sv
module ackGapDetect
  import ackGapPkg::*;
#(
  parameter int NUM_CHECKS = 4,
  parameter int FIRST_TICK = 7,
  parameter int SPACING = 12,
  parameter logic [NUM_CHECKS-1:0] EXPECT_LEVELS = 4'b1010
) (
  input  logic clk,
  input  logic rstN,
  input  logic ackEnable,
  input  logic quarterTick,
  input  logic codeEnd,
  input  logic gapLevel,
  output logic ackPulse,
  output logic failPulse
);

  dpStrobe_t strobe;
  logic atSample, levelOk, lastCheck;

  ackGapControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ackEnable  (ackEnable),
    .codeEnd    (codeEnd),
    .quarterTick(quarterTick),
    .atSample   (atSample),
    .levelOk    (levelOk),
    .lastCheck  (lastCheck),
    .strobe     (strobe),
    .ackPulse   (ackPulse),
    .failPulse  (failPulse)
  );

  ackGapDatapath #(
    .NUM_CHECKS   (NUM_CHECKS),
    .FIRST_TICK   (FIRST_TICK),
    .SPACING      (SPACING),
    .EXPECT_LEVELS(EXPECT_LEVELS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .quarterTick(quarterTick),
    .gapLevel   (gapLevel),
    .atSample   (atSample),
    .levelOk    (levelOk),
    .lastCheck  (lastCheck)
  );

endmodule

// File: tb/ackGapDetect_test.sv
module ackGapDetect_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ackEnable = 1'b1;
  logic quarterTick = 1'b0;
  logic codeEnd = 1'b0;
  logic gapLevel = 1'b0;
  logic ackPulse, failPulse;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ackGapDetect uut (
    .clk        (clk),
    .rstN       (rstN),
    .ackEnable  (ackEnable),
    .quarterTick(quarterTick),
    .codeEnd    (codeEnd),
    .gapLevel   (gapLevel),
    .ackPulse   (ackPulse),
    .failPulse  (failPulse)
  );

  localparam logic [3:0] GOOD = 4'b1010;

  task automatic check(input string req, input string what, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // mode: 0 low between samples, 1 high, 2 opposite of the next expected level
  // start: 0 no codeEnd, 1 codeEnd alone, 2 codeEnd together with a tick
  task automatic runSeq(input logic [3:0] lv, input int mode, input int nTicks,
                        input int start, input int disableAt, input bit live0,
                        input string req);
    bit live;
    live = live0;
    if (start == 1) begin
      codeEnd = 1'b1;
      @(negedge clk);
      codeEnd = 1'b0;
    end else if (start == 2) begin
      codeEnd = 1'b1;
      quarterTick = 1'b1;
      gapLevel = 1'b1;
      @(negedge clk);
      codeEnd = 1'b0;
      quarterTick = 1'b0;
    end
    for (int t = 1; t <= nTicks; t++) begin
      int k;
      bit isSample;
      bit eA, eF;
      logic lvl;
      if (t == disableAt) begin
        ackEnable = 1'b0;
        @(negedge clk);
        ackEnable = 1'b1;
        live = 1'b0;
      end
      k = (t <= 7) ? 0 : ((t - 7 + 11) / 12);
      if (k > 3) k = 3;
      isSample = (t >= 7) && (t <= 43) && (((t - 7) % 12) == 0);
      if (isSample) lvl = lv[k];
      else if (mode == 0) lvl = 1'b0;
      else if (mode == 1) lvl = 1'b1;
      else lvl = ~k[0];
      eA = 1'b0;
      eF = 1'b0;
      if (live && isSample) begin
        if (lv[k] != k[0]) begin
          eF = 1'b1;
          live = 1'b0;
        end else if (k == 3) begin
          eA = 1'b1;
          live = 1'b0;
        end
      end
      gapLevel = lvl;
      quarterTick = 1'b1;
      @(negedge clk);
      quarterTick = 1'b0;
      check(req, $sformatf("ackPulse after tick %0d", t), int'(ackPulse), int'(eA));
      check(req, $sformatf("failPulse after tick %0d", t), int'(failPulse), int'(eF));
      @(negedge clk);
      // R9: the pulse has ended one cycle later
      check("R9", $sformatf("ackPulse cycle after tick %0d", t), int'(ackPulse), 0);
      check("R9", $sformatf("failPulse cycle after tick %0d", t), int'(failPulse), 0);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "ackPulse in reset", int'(ackPulse), 0);
    check("R1", "failPulse in reset", int'(failPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "ackPulse after reset", int'(ackPulse), 0);
    check("R1", "failPulse after reset", int'(failPulse), 0);
  endtask

  task automatic testGood();
    runSeq(GOOD, 2, 43, 1, 0, 1'b1, "R4");
    runSeq(GOOD, 0, 43, 1, 0, 1'b1, "R6");
    runSeq(GOOD, 1, 43, 1, 0, 1'b1, "R6");
  endtask

  task automatic testFailEach();
    for (int i = 0; i < 4; i++) begin
      runSeq(GOOD ^ (4'b0001 << i), 2, 43, 1, 0, 1'b1, (i == 0) ? "R2" : "R3");
      runSeq(GOOD ^ (4'b0001 << i), 0, 43, 1, 0, 1'b1, "R5");
    end
  endtask

  task automatic testDisable();
    // R7: codeEnd with the enable low starts nothing
    ackEnable = 1'b0;
    runSeq(GOOD, 2, 43, 1, 0, 1'b0, "R7");
    ackEnable = 1'b1;
    // R7: dropping the enable in mid-sequence aborts it
    runSeq(GOOD, 2, 43, 1, 10, 1'b1, "R7");
  endtask

  task automatic testRestart();
    // R8: a partial sequence, then a fresh start, then a start that coincides with a tick
    runSeq(GOOD, 2, 20, 1, 0, 1'b1, "R8");
    runSeq(GOOD, 2, 43, 1, 0, 1'b1, "R8");
    runSeq(GOOD, 2, 30, 1, 0, 1'b1, "R8");
    runSeq(GOOD, 2, 43, 2, 0, 1'b1, "R8");
  endtask

  task automatic testStray();
    // R10: ticks with no start strobe
    runSeq(GOOD, 2, 50, 0, 0, 1'b0, "R10");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testGood();
    testFailEach();
    testDisable();
    testRestart();
    testStray();
    finish();
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

endmodule